// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block sits between a host-side register interface and a PCI master engine. It receives a configuration request: a 32-bit configuration-address word, a read/write flag and write data. It checks the requested bus number against a bus-window register that holds the bridge's own bus number and the highest bus number reachable behind it. From that check it either builds a type 0 or a type 1 configuration address phase for the master engine, or it rejects the request. A rejected request starts no PCI cycle and ends in a one-cycle error pulse on the response side.

For type 0 cycles the target device is selected by a single IDSEL bit on the upper address lines. Device n drives bit 16+n. Only the first `NUM_IDSEL` devices are decoded. The block also flags when the address phase selects the bridge's own IDSEL line. A read that ends in a master abort completes normally and returns all ones. A rejected write is answered in the cycle after the request. A rejected read is answered only after a timeout of `TIMEOUT` cycles.

Configuration-address word layout (a block of this project's own):

| Bits | Field |
|------|-------|
| [23:19] | device |
| [18:16] | function |
| [15:8] | bus |
| [7:2] | register |

In the bus-window register, the own bus number is at [15:8] and the highest subordinate bus number is at [31:24].

Top module: `cfg_addr_gen`

## Requirements
- R1: When the requested bus equals the own bus number, the block issues a type 0 address: AD[1:0]=00, register number on AD[7:2], function on AD[10:8], AD[15:11]=0.
- R2: When the requested bus is greater than the own bus number and at most the subordinate maximum, the block issues a type 1 address: AD[1:0]=01, register on AD[7:2], function on AD[10:8], device on AD[15:11], bus on AD[23:16], AD[31:24]=0.
- R3: In a type 0 address, device n below `NUM_IDSEL` (and below 16) sets exactly AD[16+n] among AD[31:16]. Any other device number leaves AD[31:16] all zero.
- R4: A write to a bus outside the window drives no PCI cycle and discards its data. rsp_valid and rsp_err are high in the cycle right after the request is accepted.
- R5: A read to a bus outside the window drives no PCI cycle. rsp_valid and rsp_err rise exactly `TIMEOUT`+1 cycles after acceptance and stay low before then.
- R6: The command code on pci_cbe is 4'b1010 for a configuration read and 4'b1011 for a configuration write. A write's data appears on pci_wdata during the address phase.
- R7: pci_valid, together with a stable pci_ad and pci_cbe, is held until pci_ready is seen. req_ready is low from acceptance until the response cycle has ended.
- R8: rsp_valid pulses one cycle after pci_done, with rsp_err low. A read returns pci_rdata and a write returns zero.
- R9: A read that completes with pci_mabort high returns 32'hFFFFFFFF with rsp_err low.
- R10: rsp_valid lasts a single cycle for each accepted request.
- R11: host_idsel is high exactly when pci_valid is high and AD bit `SELF_IDSEL_BIT` is set.
- R12: During and after synchronous reset, req_ready is 1 and pci_valid, rsp_valid and rsp_err are 0, even if a request was in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_addr | input | 32 | Configuration-address word |
| req_wdata | input | 32 | Write data |
| bus_window | input | 32 | Own bus number [15:8], subordinate maximum [31:24] |
| pci_valid | output | 1 | Address phase offered to the master engine |
| pci_ready | input | 1 | Master engine takes the address phase |
| pci_ad | output | 32 | Address-phase AD value |
| pci_cbe | output | 4 | Configuration command code |
| pci_wdata | output | 32 | Data for a configuration write |
| pci_done | input | 1 | Master engine finished the cycle |
| pci_mabort | input | 1 | Cycle ended in master abort |
| pci_rdata | input | 32 | Read data from the master engine |
| host_idsel | output | 1 | Address phase selects the bridge's own IDSEL line |
| rsp_valid | output | 1 | Response pulse to the host side |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Response read data |

## Verification
The bench places buses at both ends of the window and just outside it on each side. An off-by-one range compare would show up as a type 1 cycle where an error was due, or the reverse. It drives devices just below and at the decoded IDSEL count, and the highest device number. A decoder that ignores the count, or shifts the bit by one, would put a wrong or extra AD bit high. It counts the exact cycle of the read-error response and holds off pci_ready for several cycles. A miscounted timeout, or a handshake that drops or alters the address, would move or corrupt the observed phase. A master-abort read checks that the returned data becomes all ones instead of the bus data.

// File: rtl/cfg_pkg.sv
// Shared definitions for the configuration cycle address generator.
// Assumes the configuration-address word layout given in the brief.
package cfg_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int IDSEL_LINES = 16;   // AD[31:16]
    localparam int IDSEL_BASE  = 16;

    typedef enum logic [1:0] {
        CYC_T0  = 2'd0,
        CYC_T1  = 2'd1,
        CYC_BAD = 2'd2
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_TMO   = 3'd3,
        ST_RESP  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [4:0] dev;
        logic [2:0] func;
        logic [7:0] bus;
        logic [5:0] regn;
    } cfg_fields_t;

endpackage

// File: rtl/cfg_idsel_dec.sv
// One-hot IDSEL decoder: device n drives line n when n < NUM_IDSEL.
// Assumes NUM_IDSEL is at most cfg_pkg::IDSEL_LINES; lines beyond it stay 0.
module cfg_idsel_dec #(
    parameter int NUM_IDSEL = 16
) (
    input  logic [4:0]                       dev,
    output logic [cfg_pkg::IDSEL_LINES-1:0]  idsel
);
    // One line per possible device slot; slots past the count are tied low.
    for (genvar g = 0; g < cfg_pkg::IDSEL_LINES; g++) begin : g_line
        if (g < NUM_IDSEL) begin : g_used
            assign idsel[g] = (dev == 5'(g));
        end else begin : g_unused
            assign idsel[g] = 1'b0;
        end
    end
endmodule

// File: rtl/cfg_decode.sv
// Classifies a configuration request against the bus window and builds the
// address-phase AD value for type 0 and type 1 cycles. Purely combinational.
// Assumes own bus at bus_window[15:8] and subordinate max at [31:24].
module cfg_decode #(
    parameter int NUM_IDSEL = 16
) (
    input  logic [31:0]       cfg_word,
    input  logic [31:0]       bus_window,
    output cfg_pkg::cyc_kind_t kind,
    output logic [31:0]       ad
);
    import cfg_pkg::*;

    cfg_fields_t f;
    logic [7:0]  own_bus;
    logic [7:0]  sub_max;
    logic [IDSEL_LINES-1:0] idsel;

    // Field extraction from the request word.
    always_comb begin
        f.dev   = cfg_word[23:19];
        f.func  = cfg_word[18:16];
        f.bus   = cfg_word[15:8];
        f.regn  = cfg_word[7:2];
        own_bus = bus_window[15:8];
        sub_max = bus_window[31:24];
    end

    cfg_idsel_dec #(.NUM_IDSEL(NUM_IDSEL)) u_idsel (
        .dev   (f.dev),
        .idsel (idsel)
    );

    // Range check: equal -> type 0, inside window -> type 1, else reject.
    always_comb begin
        if (f.bus == own_bus)
            kind = CYC_T0;
        else if (f.bus > own_bus && f.bus <= sub_max)
            kind = CYC_T1;
        else
            kind = CYC_BAD;
    end

    // Address-phase formation per cycle type.
    always_comb begin
        case (kind)
            CYC_T0:  ad = {idsel, 5'b0, f.func, f.regn, 2'b00};
            CYC_T1:  ad = {8'b0, f.bus, f.dev, f.func, f.regn, 2'b01};
            default: ad = '0;
        endcase
    end
endmodule

// File: rtl/cfg_seq.sv
// Request sequencer: holds the address phase until the master engine takes
// it, waits for completion, times out rejected reads and emits one response
// pulse per request. Assumes TIMEOUT >= 1.
module cfg_seq #(
    parameter int TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  cfg_pkg::cyc_kind_t kind,
    input  logic [31:0]        ad_in,
    input  logic               write_in,
    input  logic [31:0]        wdata_in,
    input  logic               pci_ready,
    input  logic               pci_done,
    input  logic               pci_mabort,
    input  logic [31:0]        pci_rdata,
    output logic               req_ready,
    output logic               pci_valid,
    output logic [31:0]        pci_ad,
    output logic [3:0]         pci_cbe,
    output logic [31:0]        pci_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata
);
    import cfg_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT + 1);

    seq_state_t       state;
    logic [31:0]      ad_q;
    logic [3:0]       cbe_q;
    logic [31:0]      wdata_q;
    logic [31:0]      rdata_q;
    logic             wr_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt;

    // State, captured request and timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ad_q    <= '0;
            cbe_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            cnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (acc) begin
                        cnt     <= '0;
                        rdata_q <= '0;
                        wr_q    <= write_in;
                        cbe_q   <= write_in ? CMD_CFG_WR : CMD_CFG_RD;
                        if (kind == CYC_BAD) begin
                            err_q <= 1'b1;
                            ad_q  <= '0;
                            state <= write_in ? ST_RESP : ST_TMO;
                        end else begin
                            err_q   <= 1'b0;
                            ad_q    <= ad_in;
                            wdata_q <= write_in ? wdata_in : '0;
                            state   <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (pci_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (pci_done) begin
                        rdata_q <= wr_q ? '0 : (pci_mabort ? '1 : pci_rdata);
                        state   <= ST_RESP;
                    end
                end
                ST_TMO: begin
                    if (cnt == CNT_W'(TIMEOUT - 1)) state <= ST_RESP;
                    else                            cnt   <= cnt + 1'b1;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state and captured values.
    always_comb begin
        req_ready = (state == ST_IDLE);
        pci_valid = (state == ST_ISSUE);
        pci_ad    = ad_q;
        pci_cbe   = cbe_q;
        pci_wdata = wdata_q;
        rsp_valid = (state == ST_RESP);
        rsp_err   = rsp_valid && err_q;
        rsp_rdata = rsp_valid ? rdata_q : '0;
    end
endmodule

// File: rtl/cfg_addr_gen.sv
// Top: PCI configuration cycle address generator. Decodes a host request
// into a type 0 / type 1 address phase or an error response.
// Assumes SELF_IDSEL_BIT lies in 16..31 and NUM_IDSEL <= 16.
module cfg_addr_gen #(
    parameter int NUM_IDSEL      = 16,
    parameter int TIMEOUT        = 16,
    parameter int SELF_IDSEL_BIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] bus_window,
    output logic        pci_valid,
    input  logic        pci_ready,
    output logic [31:0] pci_ad,
    output logic [3:0]  pci_cbe,
    output logic [31:0] pci_wdata,
    input  logic        pci_done,
    input  logic        pci_mabort,
    input  logic [31:0] pci_rdata,
    output logic        host_idsel,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    import cfg_pkg::*;

    cyc_kind_t   kind;
    logic [31:0] ad_next;
    logic        acc;

    cfg_decode #(.NUM_IDSEL(NUM_IDSEL)) u_dec (
        .cfg_word   (req_addr),
        .bus_window (bus_window),
        .kind       (kind),
        .ad         (ad_next)
    );

    // Request acceptance handshake.
    assign acc = req_valid && req_ready;

    cfg_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .kind       (kind),
        .ad_in      (ad_next),
        .write_in   (req_write),
        .wdata_in   (req_wdata),
        .pci_ready  (pci_ready),
        .pci_done   (pci_done),
        .pci_mabort (pci_mabort),
        .pci_rdata  (pci_rdata),
        .req_ready  (req_ready),
        .pci_valid  (pci_valid),
        .pci_ad     (pci_ad),
        .pci_cbe    (pci_cbe),
        .pci_wdata  (pci_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    // Own IDSEL: the bridge is addressed when its AD line is set in a phase.
    assign host_idsel = pci_valid && pci_ad[SELF_IDSEL_BIT];
endmodule

// File: rtl/cfg_addr_gen_chk.sv
// Property checker for cfg_addr_gen, bound to every instance of the top.
module cfg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic [31:0] bus_window,
    input logic        pci_valid,
    input logic        pci_ready,
    input logic [31:0] pci_ad,
    input logic [3:0]  pci_cbe,
    input logic        host_idsel,
    input logic        rsp_valid,
    input logic        rsp_err
);
    logic out_of_window;
    // Window test from the port values, used for the write-error property.
    assign out_of_window = !((req_addr[15:8] >= bus_window[15:8]) &&
                             (req_addr[15:8] <= bus_window[31:24])) &&
                           (req_addr[15:8] != bus_window[15:8]);

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid && !pci_ready |=> pci_valid && $stable(pci_ad) && $stable(pci_cbe));

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> !req_ready);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_idsel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid && (pci_ad[1:0] == 2'b00) |-> $countones(pci_ad[31:16]) <= 1);

    assert_cmd_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> (pci_cbe == 4'b1010) || (pci_cbe == 4'b1011));

    assert_type1_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid && (pci_ad[1:0] == 2'b01) |-> pci_ad[31:24] == 8'h00);

    assert_write_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write && out_of_window
        |=> rsp_valid && rsp_err && !pci_valid);

    assert_err_in_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    assert_host_idsel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_idsel |-> pci_valid);
endmodule

bind cfg_addr_gen cfg_addr_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .bus_window (bus_window),
    .pci_valid  (pci_valid),
    .pci_ready  (pci_ready),
    .pci_ad     (pci_ad),
    .pci_cbe    (pci_cbe),
    .host_idsel (host_idsel),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err)
);

// File: tb/sim_cfg_addr_gen.sv
// Self-checking bench: vector table walk, then directed corner cases.
module sim_cfg_addr_gen;
    localparam int TMO   = 5;
    localparam int NIDS  = 12;
    localparam int SELFB = 19;
    localparam logic [31:0] WIN = 32'h0500_0200;  // own bus 2, subordinate max 5
    localparam int NV = 9;

    // {write, error, cfg word, expected AD}
    localparam logic [65:0] VECS [NV] = '{
        {1'b0, 1'b0, 32'h0019_0210, 32'h0008_0110},  // t0 dev3 func1 reg4 (own idsel)
        {1'b1, 1'b0, 32'h007F_02FC, 32'h0000_07FC},  // t0 dev15 >= count: no idsel
        {1'b0, 1'b0, 32'h0058_0200, 32'h0800_0000},  // t0 dev11, last decoded
        {1'b1, 1'b0, 32'h0002_0204, 32'h0001_0204},  // t0 dev0 func2 reg1
        {1'b0, 1'b0, 32'h0060_0200, 32'h0000_0000},  // t0 dev12, first undecoded
        {1'b0, 1'b0, 32'h002A_0320, 32'h0003_2A21},  // t1 bus3 (own+1)
        {1'b1, 1'b0, 32'h00FF_05FC, 32'h0005_FFFD},  // t1 bus5 (sub max)
        {1'b1, 1'b1, 32'h0000_0600, 32'h0000_0000},  // write bus6 > sub
        {1'b0, 1'b1, 32'h0000_0100, 32'h0000_0000}   // read bus1 < own
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0, bus_window = WIN;
    logic        pci_ready = 1'b0, pci_done = 1'b0, pci_mabort = 1'b0;
    logic [31:0] pci_rdata = '0;
    logic        req_ready, pci_valid, host_idsel, rsp_valid, rsp_err;
    logic [31:0] pci_ad, pci_wdata, rsp_rdata;
    logic [3:0]  pci_cbe;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cfg_addr_gen #(.NUM_IDSEL(NIDS), .TIMEOUT(TMO), .SELF_IDSEL_BIT(SELFB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_window(bus_window), .pci_valid(pci_valid), .pci_ready(pci_ready),
        .pci_ad(pci_ad), .pci_cbe(pci_cbe), .pci_wdata(pci_wdata),
        .pci_done(pci_done), .pci_mabort(pci_mabort), .pci_rdata(pci_rdata),
        .host_idsel(host_idsel), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Offer one request and leave it accepted; returns at the next negedge.
    task automatic offer(input bit wr, input logic [31:0] word);
        @(negedge clk);
        req_addr = word; req_write = wr; req_wdata = ~word; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R7 ready before request", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Serve an issued cycle; completes and checks the response.
    task automatic serve(input bit wr, input bit mab, input logic [31:0] rd,
                         input logic [31:0] exp_ad, input string tag);
        logic [31:0] exp_rd;
        exp_rd = wr ? 32'h0 : (mab ? 32'hFFFF_FFFF : rd);
        repeat (2) @(negedge clk);
        chk(pci_valid && pci_ad == exp_ad, "R7 phase held without ready", pci_ad, exp_ad);
        pci_ready = 1'b1;
        @(negedge clk);
        pci_ready = 1'b0;
        chk(pci_valid == 1'b0, "R7 phase ends after ready", {31'b0, pci_valid}, 32'h0);
        pci_done = 1'b1; pci_mabort = mab; pci_rdata = rd;
        @(negedge clk);
        pci_done = 1'b0; pci_mabort = 1'b0;
        chk(rsp_valid && !rsp_err && rsp_rdata == exp_rd, tag, rsp_rdata, exp_rd);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R10 response single cycle",
            {30'b0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(req_ready && !pci_valid && !rsp_valid && !rsp_err, "R12 reset state",
            {28'b0, req_ready, pci_valid, rsp_valid, rsp_err}, 32'h8);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic        wr, er;
            logic [31:0] word, ead;
            {wr, er, word, ead} = VECS[i];
            offer(wr, word);
            if (er && wr) begin
                chk(rsp_valid && rsp_err && !pci_valid, "R4 write reject next cycle",
                    {29'b0, rsp_valid, rsp_err, pci_valid}, 32'h6);
                @(negedge clk);
                chk(!rsp_valid && !pci_valid, "R10 write reject pulse ends",
                    {30'b0, rsp_valid, pci_valid}, 32'h0);
            end else if (er) begin
                for (int k = 1; k <= TMO; k++) begin
                    chk(!rsp_valid && !pci_valid, "R5 no response before timeout",
                        {30'b0, rsp_valid, pci_valid}, 32'h0);
                    @(negedge clk);
                end
                chk(rsp_valid && rsp_err, "R5 read reject at timeout",
                    {30'b0, rsp_valid, rsp_err}, 32'h3);
                @(negedge clk);
                chk(!rsp_valid, "R10 read reject pulse ends", {31'b0, rsp_valid}, 32'h0);
            end else begin
                chk(pci_valid && pci_ad == ead,
                    (ead[1:0] == 2'b01) ? "R2 type 1 address" : "R1 R3 type 0 address",
                    pci_ad, ead);
                chk(pci_cbe == (wr ? 4'b1011 : 4'b1010), "R6 command code",
                    {28'b0, pci_cbe}, {28'b0, wr ? 4'b1011 : 4'b1010});
                if (wr) chk(pci_wdata == ~word, "R6 write data", pci_wdata, ~word);
                chk(host_idsel == ead[SELFB], "R11 own idsel",
                    {31'b0, host_idsel}, {31'b0, ead[SELFB]});
                chk(!req_ready, "R7 busy while issuing", {31'b0, req_ready}, 32'h0);
                serve(wr, 1'b0, 32'hC0DE_0000 + i, ead, "R8 completion data");
            end
        end

        // R9: master abort on a read returns all ones
        offer(1'b0, 32'h0019_0210);
        serve(1'b0, 1'b1, 32'h1234_5678, 32'h0008_0110, "R9 master abort all ones");

        // R12: reset while a phase is pending
        offer(1'b1, 32'h002A_0320);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !pci_valid && !rsp_valid, "R12 reset aborts request",
            {29'b0, req_ready, pci_valid, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pci_valid && !rsp_valid, "R12 idle after reset",
            {30'b0, pci_valid, rsp_valid}, 32'h0);

        summary();
    end
endmodule